// File: doc/BRIEF.md
# I2C EEPROM Write Target

This block is the receive side of a serial EEPROM on a two-wire bus. It watches the clock and data lines of an I2C bus, recognises the start and stop conditions, and answers a bus master that addresses it for writing. After a device select byte and a two-byte memory address it takes data bytes. A single byte gives a byte write; a run of up to one full 64-byte row gives a page write. Incoming bytes are collected in a page buffer and copied into an on-chip register array only once the master closes the transfer with a clean stop condition.

A write-control input blocks programming. If it is seen high at any time between the start condition and the end of the second address byte, the select and address bytes are still acknowledged, every data byte is refused with a NoAck, and the array is left as it was. The data line is only ever pulled low, through an open-drain enable, and it only changes while the bus clock is low. A combinational read port exposes the array so the surrounding logic or a testbench can inspect its contents. The array covers the low `MEM_AW` bits of the 15-bit bus address.

Top module: `eeprom_write_target`

## Requirements
- R1: The target acknowledges a device select byte only when bits 7:4 are 1010, bits 2:1 equal `ce_i`, and bit 0 (R/W) is 0. Bit 3 is ignored. For any other select byte it pulls SDA low in no bit of the transfer and writes nothing until the next START.
- R2: After a matching select byte, both address bytes are acknowledged, even while write control is high. The memory address is the high byte's bits 6:0 followed by the low byte, so bit 7 of the high byte has no effect on where data lands.
- R3: If `wc_i` is high at any point from the START through the end of the second address byte, every data byte gets a NoAck and the array is not changed.
- R4: Byte write: a single data byte that is followed by STOP is acknowledged and stored at the addressed location.
- R5: Page write: 1 to 64 data bytes are each acknowledged and stored at consecutive locations, starting at the addressed column of one 64-byte row.
- R6: After each data byte only address bits 5:0 advance, and bits 14:6 stay fixed. A byte that runs past column 63 wraps to column 0 of the same row, and the later byte overwrites the earlier one.
- R7: Buffered bytes are written only when STOP follows directly on the acknowledge slot of a complete data byte. A STOP inside a byte, a repeated START, or a transfer with no data bytes leaves the array unchanged.
- R8: `sda_oe_o` is 0 out of reset. It is 1 only during the acknowledge clock of a byte being accepted, and it changes only while the synchronised SCL is low.
- R9: After a valid STOP, the buffered bytes reach the array one per clock in column order, and all of them are readable on `rd_data_o` within 70 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 4x faster than each SCL phase |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge); 0 releases it |
| wc_i | input | 1 | Write control; high inhibits programming |
| ce_i | input | CE_W | Chip-enable strap compared with select bits 2:1 |
| rd_addr_i | input | MEM_AW | Read-back address into the array |
| rd_data_o | output | 8 | Array contents at `rd_addr_i` (combinational) |

## Verification
On every cycle the assertions check several rules. The acknowledge enable is asserted only inside an acknowledge slot, and it only changes while SCL is low. An unselected or idle target never pulls the line. The row bits hold while data is streaming. A commit follows only a stop condition and is never accepted mid-drain, and the page buffer is never filled while a drain is running. The bench scenarios cover the rest. These show that the right bytes land at the right addresses, including wrap-around overwrites. They also show that write control or a bad select byte leaves the array unchanged. The effect of a stop in mid-byte, a repeated start, or an address-only transfer can likewise only be shown by reading the array back afterwards.

// File: rtl/eew_pkg.sv
// Shared definitions for the EEPROM write target.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package eew_pkg;
    // Upper nibble every select byte must carry to address a memory.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Link-layer position inside a bus transfer.
    typedef enum logic [2:0] {
        L_IDLE,   // no transfer, or after STOP
        L_DEV,    // receiving device select byte
        L_AHI,    // receiving high address byte
        L_ALO,    // receiving low address byte
        L_DATA,   // receiving data bytes
        L_IGN     // not selected: silent until next START
    } link_st_t;
endpackage

// File: rtl/eew_bus_sync.sv
// Brings SCL, SDA and write control into the clk domain and decodes
// bus events (START, STOP, SCL rise, SCL fall) as one-cycle strobes.
// Assumes: each SCL high or low phase lasts at least STAGES+2 clocks.
module eew_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wc_i,
    output logic scl_s,
    output logic sda_s,
    output logic wc_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    // Bit order in each stage: {wc, sda, scl}; idle bus is scl=1, sda=1.
    localparam logic [2:0] IDLE_LINES = 3'b011;

    logic [2:0] stg [STAGES];
    logic       scl_q, sda_q;

    // Synchroniser chain for all three lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_LINES;
        end else begin
            stg[0] <= {wc_i, sda_i, scl_i};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign scl_s = stg[STAGES-1][0];
    assign sda_s = stg[STAGES-1][1];
    assign wc_s  = stg[STAGES-1][2];

    // Previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_ev = scl_s && scl_q && sda_q && !sda_s;
    assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
    assign scl_rise = scl_s && !scl_q;
    assign scl_fall = !scl_s && scl_q;
endmodule

// File: rtl/eew_link.sv
// Byte-level protocol engine: shifts bits in on SCL rise, decides the
// acknowledge at the SCL fall after the 8th bit, tracks select/address/data
// phases, keeps the in-row column counter and issues buffer fills and the
// commit strobe.
// Assumes: events come from eew_bus_sync; SCL low phase >= 2 clocks.
module eew_link
    import eew_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int CE_W   = 2,
    localparam int ROW_W = ADDR_W - PAGE_W,
    localparam int HI_W  = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              wc_s,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic [CE_W-1:0]   ce_strap,
    output logic              ack_drive,
    output logic              bw_en,
    output logic [PAGE_W-1:0] bw_idx,
    output logic [7:0]        bw_data,
    output logic              clear_req,
    output logic              commit,
    output logic [ROW_W-1:0]  commit_row
);
    link_st_t          st;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic              in_ack;
    logic              pend_data;
    logic              after_data;
    logic              wc_lat;
    logic [HI_W-1:0]   hi_q;
    logic [ROW_W-1:0]  row_q;
    logic [PAGE_W-1:0] col_q;

    logic sel_ok;
    assign sel_ok = (shreg[7:4] == DEV_TYPE) && (shreg[CE_W:1] == ce_strap) && !shreg[0];
    assign commit_row = row_q;

    // Protocol state, shift register, acknowledge and address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= L_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            in_ack     <= 1'b0;
            pend_data  <= 1'b0;
            after_data <= 1'b0;
            wc_lat     <= 1'b0;
            hi_q       <= '0;
            row_q      <= '0;
            col_q      <= '0;
            ack_drive  <= 1'b0;
            bw_en      <= 1'b0;
            bw_idx     <= '0;
            bw_data    <= '0;
            clear_req  <= 1'b0;
            commit     <= 1'b0;
        end else begin
            bw_en     <= 1'b0;
            commit    <= 1'b0;
            clear_req <= 1'b0;
            if (start_ev) begin
                st         <= L_DEV;
                bitcnt     <= '0;
                in_ack     <= 1'b0;
                ack_drive  <= 1'b0;
                wc_lat     <= wc_s;
                after_data <= 1'b0;
                pend_data  <= 1'b0;
                clear_req  <= 1'b1;
            end else if (stop_ev) begin
                commit     <= (st == L_DATA) && after_data && (bitcnt == 4'd1) && !in_ack;
                st         <= L_IDLE;
                in_ack     <= 1'b0;
                ack_drive  <= 1'b0;
                after_data <= 1'b0;
            end else begin
                if (st == L_DEV || st == L_AHI || st == L_ALO)
                    wc_lat <= wc_lat | wc_s;
                if (st != L_IDLE && st != L_IGN) begin
                    if (scl_rise && !in_ack && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && !in_ack && bitcnt == 4'd8) begin
                        in_ack    <= 1'b1;
                        pend_data <= 1'b0;
                        case (st)
                            L_DEV: begin
                                if (sel_ok) begin
                                    ack_drive <= 1'b1;
                                    st        <= L_AHI;
                                end else begin
                                    st <= L_IGN;
                                end
                            end
                            L_AHI: begin
                                hi_q      <= shreg[HI_W-1:0];
                                ack_drive <= 1'b1;
                                st        <= L_ALO;
                            end
                            L_ALO: begin
                                {row_q, col_q} <= {hi_q, shreg};
                                ack_drive      <= 1'b1;
                                st             <= L_DATA;
                            end
                            L_DATA: begin
                                pend_data <= 1'b1;
                                if (!wc_lat) begin
                                    bw_en     <= 1'b1;
                                    bw_idx    <= col_q;
                                    bw_data   <= shreg;
                                    ack_drive <= 1'b1;
                                    col_q     <= col_q + 1'b1;
                                end
                            end
                            default: st <= L_IGN;
                        endcase
                    end else if (scl_fall && in_ack) begin
                        in_ack     <= 1'b0;
                        ack_drive  <= 1'b0;
                        bitcnt     <= '0;
                        after_data <= pend_data;
                    end
                end
            end
        end
    end

    assert_ack_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive |-> in_ack);
    assert_oe_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_drive != $past(ack_drive)) |-> !scl_s);
    assert_silent_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_IGN || st == L_IDLE) |-> !ack_drive);
    assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_DATA && $past(st) == L_DATA) |-> $stable(row_q));
    assert_commit_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_ev));
endmodule

// File: rtl/eew_store.sv
// Page buffer with per-byte valid flags, a drain engine that copies valid
// bytes into the register array one per clock after a commit, and the
// combinational read-back port.
// Assumes: no buffer fill arrives within PAGE_N clocks of a commit (held by
// bus timing: three bytes precede any data); MEM_AW >= PAGE_W.
module eew_store #(
    parameter int PAGE_W = 6,
    parameter int ROW_W  = 9,
    parameter int MEM_AW = 11,
    localparam int PAGE_N = 1 << PAGE_W,
    localparam int MEM_N  = 1 << MEM_AW,
    localparam int DROW_W = MEM_AW - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bw_en,
    input  logic [PAGE_W-1:0] bw_idx,
    input  logic [7:0]        bw_data,
    input  logic              clear_req,
    input  logic              commit,
    input  logic [ROW_W-1:0]  commit_row,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0]        pbuf [PAGE_N];
    logic [PAGE_N-1:0] pval;
    logic              drain;
    logic [PAGE_W-1:0] dptr;
    logic [DROW_W-1:0] drow;
    logic [7:0]        mem  [MEM_N];
    logic              wr_go;

    // Rows beyond the array alias onto it; upper row bits are dropped.
    generate
        if (ROW_W > DROW_W) begin : g_alias
            logic row_hi_unused;
            assign row_hi_unused = ^commit_row[ROW_W-1:DROW_W];
        end
    endgenerate

    assign wr_go = drain && pval[dptr];

    // Drain control and valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain <= 1'b0;
            dptr  <= '0;
            drow  <= '0;
            pval  <= '0;
        end else begin
            if (commit) begin
                drain <= 1'b1;
                dptr  <= '0;
                drow  <= commit_row[DROW_W-1:0];
            end else if (drain) begin
                pval[dptr] <= 1'b0;
                dptr       <= dptr + 1'b1;
                if (dptr == PAGE_W'(PAGE_N - 1)) drain <= 1'b0;
            end else if (clear_req) begin
                pval <= '0;
            end
            if (bw_en) pval[bw_idx] <= 1'b1;
        end
    end

    // Page buffer data (no reset: qualified by pval).
    always_ff @(posedge clk) begin
        if (bw_en) pbuf[bw_idx] <= bw_data;
    end

    // Storage array (no reset: models non-volatile contents).
    always_ff @(posedge clk) begin
        if (wr_go) mem[{drow, dptr}] <= pbuf[dptr];
    end

    assign rd_data = mem[rd_addr];

    assert_no_fill_in_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bw_en |-> !drain);
    assert_commit_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !drain);
endmodule

// File: rtl/eeprom_write_target.sv
// Top of the EEPROM write target: line synchroniser, protocol engine and
// page store. SDA is pulled low only through sda_oe_o.
// Assumes: clk at least 4x faster than each SCL phase; ce_i static.
module eeprom_write_target #(
    parameter int ADDR_W      = 15,
    parameter int PAGE_W      = 6,
    parameter int MEM_AW      = 11,
    parameter int CE_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wc_i,
    input  logic [CE_W-1:0]   ce_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic scl_s, sda_s, wc_s, start_ev, stop_ev, scl_rise, scl_fall;
    logic              bw_en, clear_req, commit;
    logic [PAGE_W-1:0] bw_idx;
    logic [7:0]        bw_data;
    logic [ROW_W-1:0]  commit_row;

    eew_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wc_i(wc_i),
        .scl_s(scl_s), .sda_s(sda_s), .wc_s(wc_s), .start_ev(start_ev),
        .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    eew_link #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CE_W(CE_W)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .wc_s(wc_s),
        .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .ce_strap(ce_i), .ack_drive(sda_oe_o),
        .bw_en(bw_en), .bw_idx(bw_idx), .bw_data(bw_data),
        .clear_req(clear_req), .commit(commit), .commit_row(commit_row)
    );

    eew_store #(.PAGE_W(PAGE_W), .ROW_W(ROW_W), .MEM_AW(MEM_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .bw_en(bw_en), .bw_idx(bw_idx),
        .bw_data(bw_data), .clear_req(clear_req), .commit(commit),
        .commit_row(commit_row), .rd_addr(rd_addr_i), .rd_data(rd_data_o)
    );
endmodule

// File: tb/test_eeprom_write_target.sv
module test_eeprom_write_target;
    localparam int Q = 6;
    localparam logic [1:0] STRAP = 2'b10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, scl, sda_m, wc;
    logic [1:0]  ce;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data;
    logic        sda_oe;
    logic        sda_bus;
    assign sda_bus = sda_m & ~sda_oe;

    eeprom_write_target i_eeprom_write_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .wc_i(wc), .ce_i(ce), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0] shadow [2048];
    bit         sh_v   [2048];

    // {wc, ce, addr_hi, addr_lo, count, seed}
    localparam logic [34:0] VEC [0:7] = '{
        {1'b0, 2'd2, 8'h00, 8'h10, 8'd1,  8'h5A},
        {1'b0, 2'd2, 8'h01, 8'h40, 8'd16, 8'h20},
        {1'b0, 2'd2, 8'h01, 8'hF8, 8'd12, 8'h90},
        {1'b1, 2'd2, 8'h00, 8'h10, 8'd1,  8'hC3},
        {1'b0, 2'd2, 8'h82, 8'h05, 8'd3,  8'h44},
        {1'b0, 2'd2, 8'h03, 8'h00, 8'd64, 8'h00},
        {1'b0, 2'd2, 8'h03, 8'h80, 8'd70, 8'h80},
        {1'b0, 2'd1, 8'h00, 8'h10, 8'd1,  8'h77}
    };
    string vtag [8] = '{"R4", "R5", "R6", "R3", "R2", "R5", "R6", "R1"};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(Q);
        scl = 1'b1;   waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl = 1'b0;   waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(Q);
        scl = 1'b1;   waitc(Q);
        sda_m = 1'b1; waitc(Q);
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        sda_m = b;  waitc(Q);
        scl = 1'b1; waitc(Q);
        seen = sda_bus;
        waitc(Q);
        scl = 1'b0; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        rd_addr = a[10:0];
        waitc(1);
        d = rd_data;
    endtask

    function automatic int map_idx(input logic [7:0] hi, input logic [7:0] lo, input int i);
        int base;
        base = {hi[6:0], lo} & 15'h7FC0;
        return (base | ((lo[5:0] + i) & 63)) & 2047;
    endfunction

    task automatic verify_row(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic [7:0] d;
        waitc(100);
        for (int c = 0; c < 64; c++) begin
            int idx;
            idx = map_idx(hi, {lo[7:6], 6'd0}, c);
            if (sh_v[idx]) begin
                rd(idx, d);
                chk(d === shadow[idx], req, d, shadow[idx]);
            end
        end
    endtask

    // Vector walk
    task automatic run_vectors();
        for (int v = 0; v < 8; v++) begin
            logic        v_wc;
            logic [1:0]  v_ce;
            logic [7:0]  v_hi, v_lo, v_n, v_seed;
            bit          a_dev, a_hi, a_lo, a_d;
            int          acks, exp_acks;
            bit          sel;
            {v_wc, v_ce, v_hi, v_lo, v_n, v_seed} = VEC[v];
            sel = (v_ce == STRAP);
            wc = v_wc;
            waitc(8);
            bus_start();
            send_byte({4'b1010, 1'b0, v_ce, 1'b0}, a_dev);
            send_byte(v_hi, a_hi);
            send_byte(v_lo, a_lo);
            acks = 0;
            for (int i = 0; i < int'(v_n); i++) begin
                send_byte(v_seed + 8'(i), a_d);
                if (a_d) acks++;
            end
            bus_stop();
            wc = 1'b0;
            chk(a_dev == sel, "R1 select ack", a_dev, sel);
            if (sel) chk(a_hi && a_lo, "R2 address acks", {a_hi, a_lo}, 3);
            else     chk(!a_hi && !a_lo, "R1 silent after bad select", {a_hi, a_lo}, 0);
            exp_acks = (sel && !v_wc) ? int'(v_n) : 0;
            chk(acks == exp_acks, {vtag[v], " data acks"}, acks, exp_acks);
            if (exp_acks > 0)
                for (int i = 0; i < int'(v_n); i++) begin
                    int idx;
                    idx = map_idx(v_hi, v_lo, i);
                    shadow[idx] = v_seed + 8'(i);
                    sh_v[idx] = 1'b1;
                end
            verify_row(v_hi, v_lo, vtag[v]);
        end
    endtask

    initial begin
        logic [7:0] d;
        bit a0, a1, a2, a3, s;
        scl = 1'b1; sda_m = 1'b1; wc = 1'b0; ce = STRAP; rd_addr = '0;
        rst_n = 1'b0;
        waitc(6);
        rst_n = 1'b1;
        waitc(4);
        chk(sda_oe == 1'b0, "R8 reset oe", sda_oe, 0);

        run_vectors();
        chk(sda_oe == 1'b0, "R8 oe released after stop", sda_oe, 0);

        // R1: read request (R/W=1) is not acknowledged
        bus_start();
        send_byte({4'b1010, 1'b0, STRAP, 1'b1}, a0);
        bus_stop();
        chk(!a0, "R1 read select nack", a0, 0);

        // R7: STOP in the middle of the next byte writes nothing
        bus_start();
        send_byte({4'b1010, 1'b0, STRAP, 1'b0}, a0);
        send_byte(8'h00, a1);
        send_byte(8'h10, a2);
        send_byte(8'hEE, a3);
        chk(a3, "R7 data accepted before abort", a3, 1);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        bus_stop();
        waitc(100);
        rd(16'h0010, d);
        chk(d === 8'h5A, "R7 mid-byte stop", d, 8'h5A);

        // R7: repeated START after data, then an address-only transfer
        bus_start();
        send_byte({4'b1010, 1'b0, STRAP, 1'b0}, a0);
        send_byte(8'h01, a1);
        send_byte(8'h40, a2);
        send_byte(8'hAB, a3);
        bus_start();
        send_byte({4'b1010, 1'b0, STRAP, 1'b0}, a0);
        send_byte(8'h01, a1);
        send_byte(8'h41, a2);
        bus_stop();
        chk(a0 && a1 && a2, "R2 acks after repeated start", {a0, a1, a2}, 7);
        waitc(100);
        rd(16'h0140, d);
        chk(d === 8'h20, "R7 repeated start discards", d, 8'h20);
        rd(16'h0141, d);
        chk(d === 8'h21, "R7 no-data transfer", d, 8'h21);

        // R3: write control pulses high only inside the low address byte
        bus_start();
        send_byte({4'b1010, 1'b0, STRAP, 1'b0}, a0);
        send_byte(8'h03, a1);
        sda_m = 1'b0; waitc(2);
        wc = 1'b1; waitc(20); wc = 1'b0;
        send_byte(8'h00, a2);
        send_byte(8'hE1, a3);
        bus_stop();
        chk(a1 && a2, "R3 address acked under write control", {a1, a2}, 3);
        chk(!a3, "R3 data nack after wc pulse", a3, 0);
        waitc(100);
        rd(16'h0300, d);
        chk(d === 8'h00, "R3 memory unchanged", d, 8'h00);

        // R4: recovery, byte write at the same spot
        bus_start();
        send_byte({4'b1010, 1'b0, STRAP, 1'b0}, a0);
        send_byte(8'h03, a1);
        send_byte(8'h00, a2);
        send_byte(8'h3C, a3);
        bus_stop();
        chk(a3, "R4 data ack", a3, 1);
        waitc(70);
        rd(16'h0300, d);
        chk(d === 8'h3C, "R4 byte write stored", d, 8'h3C);
        rd(16'h0301, d);
        chk(d === 8'h01, "R4 neighbour untouched", d, 8'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule